// File: doc/BRIEF.md
# Power-Up Reset Sequencer

This block takes a device from an unpowered or reset condition to running code in a fixed, timed order. It first enables the fast RC oscillator and the crystal oscillator. After the RC start-up time, it waits for the supply comparator to report a good supply against a built-in default threshold, and only then turns on the core regulators. Once the regulators have settled, it starts memory initialisation. During that phase it fetches a user supply threshold over a request/acknowledge handshake and drives it to the comparator. After a short settle it checks the supply again against the new threshold. Core reset and then peripheral reset are released only when that second check passes.

Five reset-request lines can restart the sequence at any time: power-on/brown-out, external pin, software, watchdog and supply detect. A supply drop seen while the default threshold is in force also restarts it, and so does a drop after release. A sticky cause register records which source triggered each restart. Every wait is a cycle count derived from a clock-frequency parameter and rounded up, so no delay is ever shorter than its minimum. The asynchronous request lines and the comparator flag each pass through two flip-flop stages before the controller acts on them.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `arst_n` is low, all enables and reset releases are low, `sup_thr_o` equals the default threshold `TH_DEF`, and `cause_o` is 5'b00001. After release, `osc_en_o` rises first, with every other enable still low.
- R2: `reg_en_o` rises no sooner than ceil(13 µs × CLK_HZ) cycles after `osc_en_o`. It does not rise while the synchronised comparator flag is low under the default threshold.
- R3: `reg_en_o` stays on for at least ceil(15 µs × CLK_HZ) cycles before `mem_init_o` and `cfg_req_o` rise together.
- R4: `cfg_req_o` stays high during memory initialisation until `cfg_ack_i` is seen with it. On that edge `cfg_thr_i` is captured and `sup_thr_o` switches to it. An acknowledge outside a pending request changes nothing.
- R5: `mem_init_o` lasts at least ceil(150 µs × CLK_HZ) cycles, and in any case until the user threshold has been received.
- R6: After `mem_init_o` falls, `core_rst_n_o` rises following ceil(2.5 µs × CLK_HZ) cycles if the supply passes the user threshold. `periph_rst_n_o` follows exactly one cycle later.
- R7: If the check against the user threshold fails, both reset releases stay low with no time limit. `core_rst_n_o` rises on the third clock edge after the comparator reports good.
- R8: Any request line that is high when sampled drives every output low and restores the default threshold by the third clock edge. The block holds there while the line stays high and restarts from the oscillator step once it drops.
- R9: A low comparator flag during regulator settle, during memory initialisation before the acknowledge, or after release restarts the sequence by the third edge and sets cause bit 4.
- R10: `cause_o` bits are 0 power-on/brown-out, 1 external, 2 software, 3 watchdog, 4 supply detect. A source sets its bit when it triggers, and bits accumulate. A one on `cause_clr_i[n]` clears bit n. A power-on request leaves only bit 0 set.
- R11: Driving `arst_n` low forces all outputs to their reset values at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| arst_n | input | 1 | Asynchronous active-low power-up reset of the controller |
| rst_req_i | input | 5 | Asynchronous reset-request lines, one per source, in cause-bit order |
| sup_ok_i | input | 1 | Comparator flag: supply above the applied threshold |
| sup_thr_o | output | TH_W | Threshold value applied to the supply comparator |
| cfg_req_o | output | 1 | Request to read the user threshold |
| cfg_ack_i | input | 1 | Acknowledge of the threshold read; data valid with it |
| cfg_thr_i | input | TH_W | User threshold value |
| osc_en_o | output | 1 | Enable for the RC and crystal oscillators |
| reg_en_o | output | 1 | Enable for the core regulators |
| mem_init_o | output | 1 | Memory initialisation phase active |
| core_rst_n_o | output | 1 | Core reset, high when released |
| periph_rst_n_o | output | 1 | Peripheral reset, high when released |
| cause_clr_i | input | 5 | Write-one-to-clear strobes for the cause bits |
| cause_o | output | 5 | Sticky reset-cause bits |

## Verification
The hardest state to reach is the hold after a failed second supply check. Getting there needs a supply that clears the default threshold but not the user threshold, and the comparator must see the threshold switch while the bench still controls the supply level. The bench models the comparator as a comparison between a supply level it sets and `sup_thr_o`. It chooses a level between the two thresholds, holds it far beyond any timer, and then raises it to check that release follows within the synchronisation delay. A second hard case is a power-on request that arrives directly behind a watchdog pulse. Its only visible effect is that the cause register ends with bit 0 alone.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int unsigned NSRC    = 5;
    localparam int unsigned SRC_POR = 0;
    localparam int unsigned SRC_EXT = 1;
    localparam int unsigned SRC_SW  = 2;
    localparam int unsigned SRC_WDT = 3;
    localparam int unsigned SRC_SVD = 4;

    typedef enum logic [2:0] {
        ST_HOLD       = 3'd0,
        ST_RC_WAIT    = 3'd1,
        ST_SUP_DEF    = 3'd2,
        ST_REG_SETTLE = 3'd3,
        ST_MEM_INIT   = 3'd4,
        ST_USR_SETTLE = 3'd5,
        ST_USR_HOLD   = 3'd6,
        ST_RUN        = 3'd7
    } seq_state_e;

    // Minimum delay in cycles, rounded up, never below one cycle.
    function automatic int unsigned ns_to_cyc(input longint unsigned hz,
                                              input longint unsigned ns);
        longint unsigned prod;
        longint unsigned cyc;
        prod = hz * ns;
        cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
        if (cyc == 0) cyc = 1;
        return int'(cyc);
    endfunction

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) stg_q[s] <= '0;
                else         stg_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) stg_q[s] <= '0;
                else         stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          done_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)            cnt_d = val_i;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/pwr_seq_cause.sv
module pwr_seq_cause #(
    parameter int unsigned N       = 5,
    parameter int unsigned POR_BIT = 0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] cause_o
);

    localparam logic [N-1:0] POR_ONLY = N'(1) << POR_BIT;

    logic [N-1:0] cause_d, cause_q;

    always_comb begin
        if (set_i[POR_BIT]) cause_d = POR_ONLY;
        else                cause_d = (cause_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cause_q <= POR_ONLY;
        else         cause_q <= cause_d;
    end

    assign cause_o = cause_q;

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int unsigned     CLK_HZ      = 200_000_000,
    parameter int unsigned     TH_W        = 8,
    parameter logic [TH_W-1:0] TH_DEF      = 8'h20,
    parameter int unsigned     T_RC_NS     = 13_000,
    parameter int unsigned     T_REG_NS    = 15_000,
    parameter int unsigned     T_MEM_NS    = 150_000,
    parameter int unsigned     T_USR_NS    = 2_500,
    parameter int unsigned     SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            arst_n,
    input  logic [NSRC-1:0] rst_req_i,
    input  logic            sup_ok_i,
    output logic [TH_W-1:0] sup_thr_o,
    output logic            cfg_req_o,
    input  logic            cfg_ack_i,
    input  logic [TH_W-1:0] cfg_thr_i,
    output logic            osc_en_o,
    output logic            reg_en_o,
    output logic            mem_init_o,
    output logic            core_rst_n_o,
    output logic            periph_rst_n_o,
    input  logic [NSRC-1:0] cause_clr_i,
    output logic [NSRC-1:0] cause_o
);

    localparam int unsigned CYC_RC  = ns_to_cyc(64'(CLK_HZ), 64'(T_RC_NS));
    localparam int unsigned CYC_REG = ns_to_cyc(64'(CLK_HZ), 64'(T_REG_NS));
    localparam int unsigned CYC_MEM = ns_to_cyc(64'(CLK_HZ), 64'(T_MEM_NS));
    localparam int unsigned CYC_USR = ns_to_cyc(64'(CLK_HZ), 64'(T_USR_NS));
    localparam int unsigned MAX_A   = (CYC_RC > CYC_REG) ? CYC_RC : CYC_REG;
    localparam int unsigned MAX_B   = (CYC_MEM > CYC_USR) ? CYC_MEM : CYC_USR;
    localparam int unsigned CYC_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CW      = $clog2(CYC_MAX + 1);

    localparam logic [CW-1:0] LD_RC  = CW'(CYC_RC  - 1);
    localparam logic [CW-1:0] LD_REG = CW'(CYC_REG - 1);
    localparam logic [CW-1:0] LD_MEM = CW'(CYC_MEM - 1);
    localparam logic [CW-1:0] LD_USR = CW'(CYC_USR - 1);

    typedef struct packed {
        seq_state_e      st;
        logic            got;
        logic            periph;
        logic [TH_W-1:0] usr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NSRC-1:0] req_s;
    logic            ok_s;
    logic            tmr_load;
    logic [CW-1:0]   tmr_val;
    logic            tmr_done;
    logic            trig;
    logic            svd_drop;
    logic [NSRC-1:0] cause_set;

    pwr_seq_sync #(
        .W      (NSRC + 1),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d_i    ({sup_ok_i, rst_req_i}),
        .q_o    ({ok_s, req_s})
    );

    pwr_seq_timer #(
        .CW (CW)
    ) u_timer (
        .clk    (clk),
        .arst_n (arst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .done_o (tmr_done)
    );

    always_comb begin
        trig     = |req_s;
        svd_drop = !ok_s && ((ctl_q.st == ST_REG_SETTLE) ||
                             (ctl_q.st == ST_MEM_INIT && !ctl_q.got) ||
                             (ctl_q.st == ST_RUN));
        cause_set = req_s;
        cause_set[SRC_SVD] = req_s[SRC_SVD] | svd_drop;
    end

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (trig || svd_drop) begin
            ctl_d.st     = ST_HOLD;
            ctl_d.got    = 1'b0;
            ctl_d.periph = 1'b0;
        end else begin
            unique case (ctl_q.st)
                ST_HOLD: begin
                    ctl_d.st = ST_RC_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RC;
                end
                ST_RC_WAIT: begin
                    if (tmr_done) ctl_d.st = ST_SUP_DEF;
                end
                ST_SUP_DEF: begin
                    if (ok_s) begin
                        ctl_d.st = ST_REG_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = LD_REG;
                    end
                end
                ST_REG_SETTLE: begin
                    if (tmr_done) begin
                        ctl_d.st = ST_MEM_INIT;
                        tmr_load = 1'b1;
                        tmr_val  = LD_MEM;
                    end
                end
                ST_MEM_INIT: begin
                    if (cfg_ack_i && !ctl_q.got) begin
                        ctl_d.got = 1'b1;
                        ctl_d.usr = cfg_thr_i;
                    end
                    if (tmr_done && ctl_q.got) begin
                        ctl_d.st = ST_USR_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = LD_USR;
                    end
                end
                ST_USR_SETTLE: begin
                    if (tmr_done) ctl_d.st = ok_s ? ST_RUN : ST_USR_HOLD;
                end
                ST_USR_HOLD: begin
                    if (ok_s) ctl_d.st = ST_RUN;
                end
                ST_RUN: begin
                    ctl_d.periph = 1'b1;
                end
                default: ctl_d.st = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ctl_q.st     <= ST_HOLD;
            ctl_q.got    <= 1'b0;
            ctl_q.periph <= 1'b0;
            ctl_q.usr    <= TH_DEF;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pwr_seq_cause #(
        .N       (NSRC),
        .POR_BIT (SRC_POR)
    ) u_cause (
        .clk     (clk),
        .arst_n  (arst_n),
        .set_i   (cause_set),
        .clr_i   (cause_clr_i),
        .cause_o (cause_o)
    );

    assign osc_en_o       = (ctl_q.st != ST_HOLD);
    assign reg_en_o       = (ctl_q.st == ST_REG_SETTLE) || (ctl_q.st == ST_MEM_INIT) ||
                            (ctl_q.st == ST_USR_SETTLE) || (ctl_q.st == ST_USR_HOLD) ||
                            (ctl_q.st == ST_RUN);
    assign mem_init_o     = (ctl_q.st == ST_MEM_INIT);
    assign cfg_req_o      = (ctl_q.st == ST_MEM_INIT) && !ctl_q.got;
    assign sup_thr_o      = ctl_q.got ? ctl_q.usr : TH_DEF;
    assign core_rst_n_o   = (ctl_q.st == ST_RUN);
    assign periph_rst_n_o = ctl_q.periph;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
    import pwr_seq_pkg::*;
#(
    parameter int unsigned TH_W = 8
) (
    input logic            clk,
    input logic            arst_n,
    input logic [NSRC-1:0] req_s,
    input logic            ok_s,
    input logic            cfg_req_o,
    input logic            cfg_ack_i,
    input logic [TH_W-1:0] cfg_thr_i,
    input logic [TH_W-1:0] sup_thr_o,
    input logic            osc_en_o,
    input logic            reg_en_o,
    input logic            mem_init_o,
    input logic            core_rst_n_o,
    input logic            periph_rst_n_o,
    input logic [NSRC-1:0] cause_o
);

    // R2
    reg_after_osc_chk: assert property (@(posedge clk) disable iff (!arst_n)
        reg_en_o |-> osc_en_o);

    // R3
    mem_after_reg_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(mem_init_o) |-> reg_en_o && $past(reg_en_o));

    // R4
    req_in_init_chk: assert property (@(posedge clk) disable iff (!arst_n)
        cfg_req_o |-> mem_init_o);

    // R4
    ack_capture_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (cfg_req_o && cfg_ack_i && !(|req_s) && ok_s) |=>
            (!cfg_req_o && sup_thr_o == $past(cfg_thr_i)));

    // R6
    core_powered_chk: assert property (@(posedge clk) disable iff (!arst_n)
        core_rst_n_o |-> (osc_en_o && reg_en_o && !mem_init_o));

    // R6
    periph_after_core_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(periph_rst_n_o) |-> $past(core_rst_n_o));

    // R8
    req_forces_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (|req_s) |=> (!osc_en_o && !core_rst_n_o && !periph_rst_n_o));

    // R10
    por_clears_cause_chk: assert property (@(posedge clk) disable iff (!arst_n)
        req_s[SRC_POR] |=> (cause_o == NSRC'(1)));

endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.TH_W(TH_W)) u_chk (
    .clk            (clk),
    .arst_n         (arst_n),
    .req_s          (req_s),
    .ok_s           (ok_s),
    .cfg_req_o      (cfg_req_o),
    .cfg_ack_i      (cfg_ack_i),
    .cfg_thr_i      (cfg_thr_i),
    .sup_thr_o      (sup_thr_o),
    .osc_en_o       (osc_en_o),
    .reg_en_o       (reg_en_o),
    .mem_init_o     (mem_init_o),
    .core_rst_n_o   (core_rst_n_o),
    .periph_rst_n_o (periph_rst_n_o),
    .cause_o        (cause_o)
);

// File: tb/pwr_seq_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_bench;

    localparam logic [7:0] DEF = 8'h20;

    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic [4:0] req = '0;
    logic [4:0] cause_clr = '0;
    logic       sup_ok;
    logic [7:0] thr;
    logic       cfg_req, cfg_ack;
    logic [7:0] cfg_thr;
    logic       osc_en, reg_en, mem_init, core_rst_n, periph_rst_n;
    logic [4:0] cause;

    int         vdd = 64;
    logic [7:0] usr = 8'h30;
    bit         ack_en = 1'b1;
    logic       ack_m = 1'b0;
    logic       spur = 1'b0;
    int         ack_cnt = 0;

    always #2.5 clk = ~clk;

    assign sup_ok  = (vdd >= int'(thr));
    assign cfg_ack = ack_m | spur;
    assign cfg_thr = spur ? 8'h55 : usr;

    pwr_seq_ctrl #(.CLK_HZ(3_000_000)) u_pwr_seq_ctrl (
        .clk            (clk),
        .arst_n         (arst_n),
        .rst_req_i      (req),
        .sup_ok_i       (sup_ok),
        .sup_thr_o      (thr),
        .cfg_req_o      (cfg_req),
        .cfg_ack_i      (cfg_ack),
        .cfg_thr_i      (cfg_thr),
        .osc_en_o       (osc_en),
        .reg_en_o       (reg_en),
        .mem_init_o     (mem_init),
        .core_rst_n_o   (core_rst_n),
        .periph_rst_n_o (periph_rst_n),
        .cause_clr_i    (cause_clr),
        .cause_o        (cause)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [13:0] v;
        int          lo;
        int          hi;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    function automatic logic [13:0] mk(input bit o, input bit r, input bit m,
                                       input bit q, input bit c, input bit p,
                                       input logic [7:0] t);
        return {o, r, m, q, c, p, t};
    endfunction

    task automatic push(input logic [13:0] v, input int lo, input int hi, input string tag);
        exp_t e;
        e.v = v; e.lo = lo; e.hi = hi; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    // Expected output sequence of one start-up, from oscillator enable onward.
    task automatic push_boot(input logic [7:0] u, input bit reg_dc, input bit stall,
                             input bit release_it);
        push(mk(1,0,0,0,0,0,DEF), -1, -1, "R1");
        if (reg_dc) push(mk(1,1,0,0,0,0,DEF), -1, -1, "R2");
        else        push(mk(1,1,0,0,0,0,DEF), 40, 41, "R2");
        push(mk(1,1,1,1,0,0,DEF), 45, 46, "R3");
        if (stall) begin
            push(mk(1,1,1,0,0,0,u), -1, -1, "R4");
            push(mk(1,1,0,0,0,0,u), 1, 1, "R5");
        end else begin
            push(mk(1,1,1,0,0,0,u), 2, 5, "R4");
            push(mk(1,1,0,0,0,0,u), 445, 449, "R5");
        end
        if (release_it) begin
            push(mk(1,1,0,0,1,0,u), 8, 9, "R6");
            push(mk(1,1,0,0,1,1,u), 1, 1, "R6");
        end
    endtask

    task automatic push_hold();
        push(mk(0,0,0,0,0,0,DEF), -1, -1, "R8");
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    // Configuration-read responder.
    always @(negedge clk) begin
        if (ack_m) begin
            ack_m   = 1'b0;
            ack_cnt = 0;
        end else if (cfg_req && ack_en) begin
            ack_cnt++;
            if (ack_cnt >= 3) ack_m = 1'b1;
        end
    end

    // Monitor: compares every output change against the expected queue.
    bit          mon_en = 1'b0;
    logic [13:0] prev_v = {6'b0, DEF};
    logic [13:0] cur_v;
    int          gap = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            cur_v = mk(osc_en, reg_en, mem_init, cfg_req, core_rst_n, periph_rst_n, thr);
            gap++;
            if (cur_v !== prev_v) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R8 unexpected change act=%h exp=none", cur_v);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (cur_v !== e.v || (e.lo >= 0 && (gap < e.lo || gap > e.hi))) begin
                        errors++;
                        $display("FAIL %s act=%h gap=%0d exp=%h gap=%0d..%0d",
                                 e.tag, cur_v, gap, e.v, e.lo, e.hi);
                    end
                end
                prev_v = cur_v;
                gap    = 0;
            end
        end
    end

    // Watchdog.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150_000) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150_000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 / R11 reset state
        check(!osc_en && !reg_en && !mem_init && !core_rst_n && !periph_rst_n && !cfg_req,
              "R1 outputs in reset", {osc_en, reg_en, mem_init, core_rst_n}, 0);
        check(thr == DEF, "R1 default threshold", thr, DEF);
        check(cause == 5'b00001, "R1 cause after power-up", cause, 5'b00001);

        // Scenario 1: clean power-up.
        usr = 8'h30;
        push_boot(8'h30, 1'b0, 1'b0, 1'b1);
        mon_en = 1'b1;
        arst_n = 1'b1;
        wait_drain();
        check(cause == 5'b00001, "R10 cause after boot", cause, 5'b00001);

        // R4: acknowledge without request is ignored.
        spur = 1'b1;
        @(negedge clk);
        spur = 1'b0;
        repeat (3) @(negedge clk);
        check(thr == 8'h30, "R4 stray ack ignored", thr, 8'h30);

        // Scenario 2: software reset, user check fails, then supply recovers.
        usr = 8'h2c;
        push_hold();
        push_boot(8'h2c, 1'b0, 1'b0, 1'b0);
        req[2] = 1'b1;
        @(negedge clk);
        req[2] = 1'b0;
        repeat (3) @(negedge clk);
        vdd = 8'h28;
        wait_drain();
        repeat (50) @(negedge clk);
        check(core_rst_n == 1'b0, "R7 held after failed check", core_rst_n, 0);
        check(cause == 5'b00101, "R10 software bit", cause, 5'b00101);
        push(mk(1,1,0,0,1,0,8'h2c), -1, -1, "R7");
        push(mk(1,1,0,0,1,1,8'h2c), 1, 1, "R6");
        vdd = 64;
        repeat (3) @(negedge clk);
        check(core_rst_n == 1'b1, "R7 release after recovery", core_rst_n, 1);
        wait_drain();
        cause_clr = 5'b00001;
        @(negedge clk);
        cause_clr = '0;
        @(negedge clk);
        check(cause == 5'b00100, "R10 write-one-to-clear", cause, 5'b00100);

        // Scenario 3: supply drop after release.
        usr = 8'h24;
        push_hold();
        push_boot(8'h24, 1'b1, 1'b0, 1'b1);
        vdd = 16;
        repeat (3) @(negedge clk);
        check(reg_en == 1'b0, "R9 drop restarts", reg_en, 0);
        repeat (100) @(negedge clk);
        check(reg_en == 1'b0 && osc_en == 1'b1, "R2 regulators wait for supply",
              {osc_en, reg_en}, 2'b10);
        check(cause == 5'b10100, "R9 supply-detect bit", cause, 5'b10100);
        vdd = 64;
        wait_drain();

        // Scenario 4: external reset held.
        usr = 8'h38;
        push_hold();
        push_boot(8'h38, 1'b0, 1'b0, 1'b1);
        req[1] = 1'b1;
        repeat (3) @(negedge clk);
        check(core_rst_n == 1'b0, "R8 request asserts reset", core_rst_n, 0);
        repeat (15) @(negedge clk);
        check(osc_en == 1'b0, "R8 held while request high", osc_en, 0);
        req[1] = 1'b0;
        wait_drain();
        check(cause == 5'b10110, "R10 external bit", cause, 5'b10110);

        // Scenario 5: watchdog then power-on request, with a slow threshold read.
        usr = 8'h22;
        ack_en = 1'b0;
        push_hold();
        push_boot(8'h22, 1'b0, 1'b1, 1'b1);
        req[3] = 1'b1;
        @(negedge clk);
        req[3] = 1'b0;
        req[0] = 1'b1;
        @(negedge clk);
        req[0] = 1'b0;
        repeat (4) @(negedge clk);
        check(cause == 5'b00001, "R10 power-on clears others", cause, 5'b00001);
        while (mem_init == 1'b0) @(negedge clk);
        repeat (600) @(negedge clk);
        check(mem_init == 1'b1, "R5 waits for threshold", mem_init, 1);
        ack_en = 1'b1;
        wait_drain();

        // Scenario 6: watchdog alone.
        usr = 8'h30;
        push_hold();
        push_boot(8'h30, 1'b0, 1'b0, 1'b1);
        req[3] = 1'b1;
        @(negedge clk);
        req[3] = 1'b0;
        wait_drain();
        check(cause == 5'b01001, "R10 watchdog bit", cause, 5'b01001);

        // R11: asynchronous reset between edges.
        mon_en = 1'b0;
        @(negedge clk);
        #1 arst_n = 1'b0;
        #0.5;
        check(!core_rst_n && !osc_en && !reg_en && thr == DEF,
              "R11 async reset", {core_rst_n, osc_en, reg_en}, 0);
        check(cause == 5'b00001, "R11 cause on async reset", cause, 5'b00001);

        check(exp_q.size() == 0, "R1 expected queue empty", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule